// File: doc/BRIEF.md
# Hardware Breakpoint Comparator Unit

This unit sits beside a processor core and watches two streams: the address of every instruction fetch, and the address and direction of every data memory access. When an armed watch condition is met, it raises a break request toward the on-chip debug logic. The request comes with a code that names the condition that fired. The halt mechanism and the debug transport are outside the unit.

The unit has four address comparators.

- Slots 0 and 1 compare only against the fetch address.
- Slots 2 and 3 form a combined pair. A mode field sets each of them to watch fetch addresses or data addresses. The mode field can also merge the two into one masked range watch over either space.
- Two further break sources need no comparator. One fires on any fetch flagged as a change of program flow. The other is single-step, which fires on the first fetch after it is armed.

Configuration is written through a simple register-write port. The value of `cfgData` is sampled on the rising clock edge where `cfgWe` is high.

| `cfgAddr` | Meaning |
|---|---|
| 0 to 3 | Compare value of slot 0 to 3, taken from `cfgData[ADDR_W-1:0]` |
| 4 | Control word (fields below) |
| 5 to 7 | Ignored |

Control word fields:

| Bits | Field |
|---|---|
| [3:0] | Per-slot enable, bit k for slot k |
| [6:4] | Pair mode |
| [8:7] | Slot 2 access qualifier |
| [10:9] | Slot 3 access qualifier |
| [11] | Flow-change break enable |
| [12] | Single-step arm (writing 1 arms it) |

Top module: `bkpt_unit`

## Requirements
- R1: After reset, all enables are 0, the pair mode is 0, single-step is disarmed, and `breakReq` and `breakCause` are 0.
- R2: Slot 0 and slot 1 match only when `fetchValid` is high and `fetchPc` equals the slot value. A data access never matches them.
- R3: Pair mode 0 sets both slot 2 and slot 3 to fetch addresses. Pair mode 1 sets slot 2 to fetch addresses and slot 3 to data addresses. Pair mode 2 sets both to data addresses.
- R4: A data-watching slot or data range matches only if its 2-bit qualifier accepts the access direction. Qualifier 1 accepts reads (`dataWrite`=0), 2 accepts writes, 3 accepts either, and 0 accepts none.
- R5: Pair mode 3 is a fetch range and pair mode 4 is a data range. In both, slot 2 holds the base and slot 3 holds the mask. A match needs (addr AND mask) == (base AND mask). Only the slot 2 enable bit is used, the slot 2 qualifier applies to the data range, and slots 2 and 3 give no single matches in these modes.
- R6: Pair mode values 5, 6 and 7 disable both combined slots and the range match.
- R7: A slot whose enable bit is 0 never matches.
- R8: With the flow enable set, a fetch with `flowChange` high fires. `flowChange` has no effect without `fetchValid`.
- R9: After an arm write, the first later fetch fires single-step and disarms it. A fetch in the same cycle as the arm write does not count.
- R10: `breakReq` is registered. It is high for exactly the cycle after each cycle that has a match, and `breakCause` is 0 when `breakReq` is low. The cause codes are: slot k gives code k (0 to 3), range 4, flow change 5, single-step 6.
- R11: When several conditions hold in one cycle, the lowest cause code is reported.
- R12: `clearIn` high suppresses the break for its own cycle and disarms single-step. Clear wins over an arm write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register select |
| cfgData | input | 16 | Configuration write data |
| fetchValid | input | 1 | An instruction is fetched this cycle |
| fetchPc | input | ADDR_W | Fetch address |
| flowChange | input | 1 | This fetch is a taken jump, branch, call, return or vector |
| dataValid | input | 1 | A data access happens this cycle |
| dataAddr | input | ADDR_W | Data access address |
| dataWrite | input | 1 | 1 for a write, 0 for a read |
| clearIn | input | 1 | Synchronous disarm and break suppression |
| breakReq | output | 1 | Registered break pulse |
| breakCause | output | 3 | Code of the winning condition |

## Verification
A single fetch can hit a fetch comparator, carry the flow-change flag, and consume an armed single-step, all in the same cycle. A data access in that same cycle can also hit a data-watching combined slot. The bench creates these collisions on purpose. It drives a fetch at a watched address with `flowChange` high while step is armed, and separately drives a watched fetch together with a watched data access. It then checks that exactly one pulse appears with the lowest code. It also confirms that the step arming was used up by that collision, because the following unmatched fetch produces no break.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int CFG_W   = 16;
  localparam int N_SLOT  = 4;
  localparam int N_HIT   = N_SLOT + 1;
  localparam int N_CAUSE = N_HIT + 2;
  localparam int CAUSE_W = $clog2(N_CAUSE);

  // Control-word field positions
  localparam int EN_LO   = 0;
  localparam int MODE_LO = 4;
  localparam int Q2_LO   = 7;
  localparam int Q3_LO   = 9;
  localparam int FLOW_B  = 11;
  localparam int STEP_B  = 12;

  localparam logic [2:0] CTRL_ADDR = 3'd4;

  typedef enum logic [2:0] {
    PAIR_PP     = 3'd0,
    PAIR_PD     = 3'd1,
    PAIR_DD     = 3'd2,
    PAIR_PRANGE = 3'd3,
    PAIR_DRANGE = 3'd4
  } pairMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [N_SLOT-1:0] loadSlot;
    logic [N_SLOT-1:0] slotOn;
    logic [1:0]        pairIsData;
    logic              rangeOn;
    logic              rangeIsData;
    logic [1:0]        qual2;
    logic [1:0]        qual3;
  } cmpCtl_t;

  function automatic logic qualOk(input logic [1:0] q, input logic isWrite);
    case (q)
      2'd1:    return !isWrite;
      2'd2:    return isWrite;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bkpt_datapath.sv
module bkpt_datapath
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpCtl_t           ctl,
  input  logic [ADDR_W-1:0] cfgValue,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              dataWrite,
  output logic [N_HIT-1:0]  hits
);

  logic [ADDR_W-1:0] slotVal [N_SLOT];

  // Compare-value registers, one per slot
  for (genvar k = 0; k < N_SLOT; k++) begin : g_val
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 slotVal[k] <= '0;
      else if (ctl.loadSlot[k])  slotVal[k] <= cfgValue;
    end
  end

  // Fetch-only slots
  for (genvar k = 0; k < 2; k++) begin : g_prog
    assign hits[k] = ctl.slotOn[k] & fetchValid & (fetchPc == slotVal[k]);
  end

  // Combined slots: fetch or data, per pair mode
  for (genvar k = 2; k < N_SLOT; k++) begin : g_comb
    logic [1:0] qual;
    logic       progHit;
    logic       dataHit;
    assign qual    = (k == 2) ? ctl.qual2 : ctl.qual3;
    assign progHit = fetchValid & (fetchPc == slotVal[k]);
    assign dataHit = dataValid & (dataAddr == slotVal[k]) & qualOk(qual, dataWrite);
    assign hits[k] = ctl.slotOn[k] & (ctl.pairIsData[k-2] ? dataHit : progHit);
  end

  // Masked range: slot 2 base, slot 3 mask
  logic [ADDR_W-1:0] rangeMask;
  logic              rangeProg;
  logic              rangeData;
  assign rangeMask = slotVal[3];
  assign rangeProg = fetchValid & (((fetchPc ^ slotVal[2]) & rangeMask) == '0);
  assign rangeData = dataValid & qualOk(ctl.qual2, dataWrite)
                   & (((dataAddr ^ slotVal[2]) & rangeMask) == '0);
  assign hits[N_SLOT] = ctl.rangeOn & (ctl.rangeIsData ? rangeData : rangeProg);

endmodule

// File: rtl/bkpt_control.sv
module bkpt_control
  import bkpt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [2:0]         cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               fetchValid,
  input  logic               flowChange,
  input  logic               clearIn,
  input  logic [N_HIT-1:0]   hits,
  output cmpCtl_t            ctl,
  output logic               breakReq,
  output logic [CAUSE_W-1:0] breakCause
);

  logic [N_SLOT-1:0] enReg;
  logic [2:0]        modeReg;
  logic [1:0]        q2Reg;
  logic [1:0]        q3Reg;
  logic              flowEn;
  logic              stepArmed;
  logic              ctrlWrite;

  assign ctrlWrite = cfgWe && (cfgAddr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      modeReg <= '0;
      q2Reg   <= '0;
      q3Reg   <= '0;
      flowEn  <= 1'b0;
    end else if (ctrlWrite) begin
      enReg   <= cfgData[EN_LO +: N_SLOT];
      modeReg <= cfgData[MODE_LO +: 3];
      q2Reg   <= cfgData[Q2_LO +: 2];
      q3Reg   <= cfgData[Q3_LO +: 2];
      flowEn  <= cfgData[FLOW_B];
    end
  end

  // Single-step arm: clear > arm > consume
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             stepArmed <= 1'b0;
    else if (clearIn)                      stepArmed <= 1'b0;
    else if (ctrlWrite && cfgData[STEP_B]) stepArmed <= 1'b1;
    else if (fetchValid)                   stepArmed <= 1'b0;
  end

  // Mode decode into comparator strobes
  always_comb begin
    ctl = '0;
    for (int k = 0; k < N_SLOT; k++)
      ctl.loadSlot[k] = cfgWe && (cfgAddr == 3'(k));
    ctl.slotOn[1:0] = enReg[1:0];
    ctl.qual2       = q2Reg;
    ctl.qual3       = q3Reg;
    case (modeReg)
      PAIR_PP: ctl.slotOn[3:2] = enReg[3:2];
      PAIR_PD: begin
        ctl.slotOn[3:2] = enReg[3:2];
        ctl.pairIsData  = 2'b10;
      end
      PAIR_DD: begin
        ctl.slotOn[3:2] = enReg[3:2];
        ctl.pairIsData  = 2'b11;
      end
      PAIR_PRANGE: ctl.rangeOn = enReg[2];
      PAIR_DRANGE: begin
        ctl.rangeOn     = enReg[2];
        ctl.rangeIsData = 1'b1;
      end
      default: ;
    endcase
  end

  // Cause collection and lowest-first priority
  logic [N_CAUSE-1:0] causeVec;
  logic [CAUSE_W-1:0] winner;
  assign causeVec = {stepArmed & fetchValid, flowEn & fetchValid & flowChange, hits};

  always_comb begin
    winner = '0;
    for (int i = N_CAUSE - 1; i >= 0; i--)
      if (causeVec[i]) winner = CAUSE_W'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakReq   <= 1'b0;
      breakCause <= '0;
    end else if (clearIn || causeVec == '0) begin
      breakReq   <= 1'b0;
      breakCause <= '0;
    end else begin
      breakReq   <= 1'b1;
      breakCause <= winner;
    end
  end

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [15:0]       cfgData,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              flowChange,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              dataWrite,
  input  logic              clearIn,
  output logic              breakReq,
  output logic [2:0]        breakCause
);

  cmpCtl_t          ctl;
  logic [N_HIT-1:0] hits;

  bkpt_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .fetchValid(fetchValid),
    .flowChange(flowChange),
    .clearIn   (clearIn),
    .hits      (hits),
    .ctl       (ctl),
    .breakReq  (breakReq),
    .breakCause(breakCause)
  );

  bkpt_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cfgValue  (cfgData[ADDR_W-1:0]),
    .fetchValid(fetchValid),
    .fetchPc   (fetchPc),
    .dataValid (dataValid),
    .dataAddr  (dataAddr),
    .dataWrite (dataWrite),
    .hits      (hits)
  );

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fetchValid,
  input logic       flowChange,
  input logic       dataValid,
  input logic       clearIn,
  input logic       breakReq,
  input logic [2:0] breakCause
);

  a_r10_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> $past(fetchValid || dataValid));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchValid || dataValid) |=> !breakReq);

  a_r10_cause_zero: assert property (@(posedge clk) disable iff (!rstN)
    !breakReq |-> breakCause == 3'd0);

  a_r10_cause_legal: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> breakCause <= 3'd6);

  a_r2_prog_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (breakReq && breakCause <= 3'd1) |-> $past(fetchValid));

  a_r8_flow_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (breakReq && breakCause == 3'd5) |-> $past(fetchValid && flowChange));

  a_r9_step_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (breakReq && breakCause == 3'd6) |-> $past(fetchValid));

  a_r12_clear_kills: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> !breakReq);

endmodule

bind bkpt_unit bkpt_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fetchValid(fetchValid),
  .flowChange(flowChange),
  .dataValid (dataValid),
  .clearIn   (clearIn),
  .breakReq  (breakReq),
  .breakCause(breakCause)
);

// File: tb/bkpt_unit_test.sv
`timescale 1ns/1ps
module bkpt_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchPc = '0;
  logic        flowChange = 1'b0;
  logic        dataValid = 1'b0;
  logic [15:0] dataAddr = '0;
  logic        dataWrite = 1'b0;
  logic        clearIn = 1'b0;
  logic        breakReq;
  logic [2:0]  breakCause;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic       req;
    logic [2:0] cause;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  bkpt_unit #(.ADDR_W(16)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .flowChange(flowChange),
    .dataValid(dataValid), .dataAddr(dataAddr), .dataWrite(dataWrite),
    .clearIn(clearIn), .breakReq(breakReq), .breakCause(breakCause)
  );

  function automatic logic [15:0] ctrlWord(input logic [3:0] en, input logic [2:0] mode,
      input logic [1:0] q2, input logic [1:0] q3, input logic flow, input logic step);
    return {3'b000, step, flow, q3, q2, mode, en};
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic tick(input logic we, input logic [2:0] a, input logic [15:0] d,
      input logic fv, input logic [15:0] pc, input logic fc,
      input logic dv, input logic [15:0] da, input logic dw, input logic clr,
      input logic eReq, input logic [2:0] eCause, input string tag);
    exp_t e;
    @(negedge clk);
    cfgWe = we; cfgAddr = a; cfgData = d;
    fetchValid = fv; fetchPc = pc; flowChange = fc;
    dataValid = dv; dataAddr = da; dataWrite = dw; clearIn = clr;
    e.req = eReq; e.cause = eCause; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    tick(1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 config cycle");
  endtask

  task automatic fetch(input logic [15:0] pc, input logic fc,
      input logic eReq, input logic [2:0] eCause, input string tag);
    tick(0, 0, 0, 1, pc, fc, 0, 0, 0, 0, eReq, eCause, tag);
  endtask

  task automatic dacc(input logic [15:0] ad, input logic w,
      input logic eReq, input logic [2:0] eCause, input string tag);
    tick(0, 0, 0, 0, 0, 0, 1, ad, w, 0, eReq, eCause, tag);
  endtask

  task automatic idle(input string tag);
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: pops one expected item per clock and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        vectors++;
        if (breakReq !== e.req || breakCause !== e.cause) begin
          fails++;
          $display("FAIL %s: actual req=%0b cause=%0d expected req=%0b cause=%0d",
                   e.tag, breakReq, breakCause, e.req, e.cause);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    vectors++;
    if (breakReq !== 1'b0 || breakCause !== 3'd0) begin
      fails++;
      $display("FAIL R1 reset: actual req=%0b cause=%0d expected req=0 cause=0", breakReq, breakCause);
    end
    idle("R1 idle after reset");
    fetch(16'h0000, 1, 0, 0, "R1 R7 reset slots disabled");

    // R2 fetch-only slots
    wr(0, 16'h0100);
    wr(1, 16'h0200);
    wr(4, ctrlWord(4'b0011, 3'd0, 2'd0, 2'd0, 0, 0));
    fetch(16'h0100, 0, 1, 0, "R2 slot0 hit");
    fetch(16'h0200, 0, 1, 1, "R2 slot1 hit");
    dacc(16'h0100, 0, 0, 0, "R2 data ignored by slot0");
    fetch(16'h0300, 0, 0, 0, "R2 miss");

    // R7 disable
    wr(4, ctrlWord(4'b0001, 3'd0, 2'd0, 2'd0, 0, 0));
    fetch(16'h0200, 0, 0, 0, "R7 slot1 disabled");

    // R3 pair modes
    wr(2, 16'h0400);
    wr(3, 16'h0500);
    wr(4, ctrlWord(4'b1100, 3'd0, 2'd3, 2'd3, 0, 0));
    fetch(16'h0400, 0, 1, 2, "R3 mode0 slot2 fetch");
    fetch(16'h0500, 0, 1, 3, "R3 mode0 slot3 fetch");
    dacc(16'h0500, 0, 0, 0, "R3 mode0 slot3 ignores data");
    wr(4, ctrlWord(4'b1100, 3'd1, 2'd3, 2'd3, 0, 0));
    dacc(16'h0500, 0, 1, 3, "R3 mode1 slot3 data");
    fetch(16'h0500, 0, 0, 0, "R3 mode1 slot3 ignores fetch");
    fetch(16'h0400, 0, 1, 2, "R3 mode1 slot2 fetch");

    // R4 qualifiers in mode2
    wr(4, ctrlWord(4'b1100, 3'd2, 2'd1, 2'd2, 0, 0));
    dacc(16'h0400, 0, 1, 2, "R3 R4 slot2 read ok");
    dacc(16'h0400, 1, 0, 0, "R4 slot2 write rejected");
    dacc(16'h0500, 1, 1, 3, "R4 slot3 write ok");
    dacc(16'h0500, 0, 0, 0, "R4 slot3 read rejected");
    fetch(16'h0400, 0, 0, 0, "R3 mode2 ignores fetch");
    wr(4, ctrlWord(4'b1100, 3'd2, 2'd0, 2'd2, 0, 0));
    dacc(16'h0400, 0, 0, 0, "R4 qualifier 0 never");

    // R5 range modes
    wr(2, 16'h1230);
    wr(3, 16'hFFF0);
    wr(4, ctrlWord(4'b0100, 3'd3, 2'd3, 2'd3, 0, 0));
    fetch(16'h123F, 0, 1, 4, "R5 fetch range inside");
    fetch(16'h1240, 0, 0, 0, "R5 fetch range outside");
    dacc(16'h1235, 0, 0, 0, "R5 fetch range ignores data");
    fetch(16'hFFF0, 0, 0, 0, "R5 no single match on mask slot");
    wr(4, ctrlWord(4'b1000, 3'd3, 2'd3, 2'd3, 0, 0));
    fetch(16'h1231, 0, 0, 0, "R5 range needs slot2 enable");
    wr(4, ctrlWord(4'b0100, 3'd4, 2'd3, 2'd3, 0, 0));
    dacc(16'h1231, 1, 1, 4, "R5 data range hit");
    fetch(16'h1231, 0, 0, 0, "R5 data range ignores fetch");
    wr(4, ctrlWord(4'b0100, 3'd4, 2'd2, 2'd3, 0, 0));
    dacc(16'h1231, 0, 0, 0, "R5 R4 data range qualifier");

    // R6 reserved modes
    wr(4, ctrlWord(4'b1100, 3'd5, 2'd3, 2'd3, 0, 0));
    fetch(16'h1231, 0, 0, 0, "R6 mode5 fetch");
    dacc(16'h1231, 0, 0, 0, "R6 mode5 data");
    wr(4, ctrlWord(4'b1100, 3'd7, 2'd3, 2'd3, 0, 0));
    fetch(16'h1230, 0, 0, 0, "R6 mode7 fetch");

    // R8 flow change
    wr(4, ctrlWord(4'b0000, 3'd0, 2'd0, 2'd0, 1, 0));
    fetch(16'h0700, 1, 1, 5, "R8 flow change fires");
    tick(0, 0, 0, 0, 16'h0700, 1, 0, 0, 0, 0, 0, 0, "R8 flag without fetch");
    fetch(16'h0700, 0, 0, 0, "R8 plain fetch");

    // R11 priority collisions
    wr(4, ctrlWord(4'b0001, 3'd0, 2'd0, 2'd0, 1, 1));
    fetch(16'h0100, 1, 1, 0, "R11 slot0 beats flow and step");
    fetch(16'h0300, 0, 0, 0, "R9 R11 step consumed by collision");
    wr(2, 16'h0400);
    wr(4, ctrlWord(4'b0110, 3'd2, 2'd3, 2'd0, 0, 0));
    tick(0, 0, 0, 1, 16'h0200, 0, 1, 16'h0400, 0, 0, 1, 1, "R11 slot1 beats slot2");
    dacc(16'h0400, 1, 1, 2, "R11 slot2 alone");

    // R9 single step
    wr(4, ctrlWord(4'b0000, 3'd0, 2'd0, 2'd0, 0, 1));
    idle("R9 armed idle");
    fetch(16'h0800, 0, 1, 6, "R9 step fires");
    fetch(16'h0802, 0, 0, 0, "R9 step once only");
    tick(1, 4, ctrlWord(4'b0000, 3'd0, 2'd0, 2'd0, 0, 1), 1, 16'h0804, 0, 0, 0, 0, 0, 0, 0,
         "R9 fetch during arm ignored");
    fetch(16'h0806, 0, 1, 6, "R9 next fetch fires");

    // R12 clear
    wr(4, ctrlWord(4'b0000, 3'd0, 2'd0, 2'd0, 0, 1));
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R12 clear cycle");
    fetch(16'h0808, 0, 0, 0, "R12 step disarmed");
    tick(1, 4, ctrlWord(4'b0000, 3'd0, 2'd0, 2'd0, 0, 1), 0, 0, 0, 0, 0, 0, 1, 0, 0,
         "R12 clear with arm");
    fetch(16'h080A, 0, 0, 0, "R12 clear beats arm");
    wr(4, ctrlWord(4'b0001, 3'd0, 2'd0, 2'd0, 0, 0));
    tick(0, 0, 0, 1, 16'h0100, 0, 0, 0, 0, 1, 0, 0, "R12 clear suppresses hit");

    // R10 back-to-back pulses
    fetch(16'h0100, 0, 1, 0, "R10 pulse one");
    fetch(16'h0100, 0, 1, 0, "R10 pulse two");
    idle("R10 pulse ends");
    idle("R10 drain");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule